// File: doc/BRIEF.md
# Bursty Compressed Stream Receiver

This block takes compressed audio that a host pushes in bursts over two wires only: a bit clock and a serial data line. There is no frame clock. Each rising edge of the bit clock captures one bit. Bits are collected most significant first into bytes. The block treats the input as one endless bit stream with no word boundaries, so a byte may be split across two bursts. Each completed byte goes into an internal FIFO. A downstream consumer in the system clock domain drains the FIFO through a ready/valid pair. PCM samples are not carried in this mode.

The two clock domains are bridged by the FIFO itself, which uses Gray-coded pointers. A request output tells the host when it may send the next burst. The request rises once the FIFO level has fallen to a low mark, and it falls once the level has climbed past a high mark. Bytes that arrive while the FIFO is full are discarded, and a sticky flag records the loss until the consumer clears it.

Top module: `burst_stream_rx`

## Requirements
- R1: While reset is low and right after it, outValid is 0, dataReq is 1 and overflow is 0.
- R2: serData is sampled on each rising edge of bitClk. Every 8 samples form one byte, with the first sample placed in bit 7 and the last in bit 0.
- R3: The bit count carries over pauses of bitClk. A byte started in one burst is completed by the first bits of the next burst, and a partial byte never raises outValid.
- R4: Bytes leave on outData in the order they were completed. outValid is 1 exactly when at least one byte is stored, and a byte is removed only in a system clock cycle where outValid and outReady are both 1.
- R5: dataReq goes to 0 one system clock after the stored byte count, as seen in the system domain, exceeds HIGH_MARK.
- R6: dataReq goes back to 1 one system clock after the stored byte count falls to LOW_MARK or below. Between the two marks it keeps its previous value.
- R7: A byte completed while DEPTH bytes are stored is discarded. The stored bytes and their order are unchanged.
- R8: overflow becomes 1 after a discarded byte and holds until clrOvf is 1 in a system clock cycle. A new discard in the same cycle as the clear wins.
- R9: While outValid is 1 and outReady is 0, outValid stays 1 and outData keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the consumer side |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| bitClk | input | 1 | Bit clock from the host; runs only during bursts |
| serData | input | 1 | Serial compressed data, captured on the rising edge of bitClk |
| outData | output | 8 | Oldest stored byte |
| outValid | output | 1 | outData holds a stored byte |
| outReady | input | 1 | Consumer takes the byte on this system clock edge |
| dataReq | output | 1 | Request to the host for another burst |
| overflow | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |
| clrOvf | input | 1 | Clears overflow on a system clock edge |

## Verification
A completed byte reaches outValid within three system clock edges after the last bit edge: one bit-domain pointer register and two synchronizer stages. dataReq changes one edge after that. A drop reaches overflow within five edges, through a toggle, three synchronizer flops and the sticky register. After each byte, pop or clear, the bench waits eight system clock cycles and then samples on the falling edge. All of these results have therefore settled when it checks them. The occupancy that decides dataReq is counted by the bench one byte at a time. Every level from empty to full is visited, both while filling and while draining.

// File: rtl/burst_rx_pkg.sv
package burst_rx_pkg;

  // strobes issued by the control block to the datapath
  typedef struct packed {
    logic pop;
  } rxStrobes_t;

endpackage

// File: rtl/burst_rx_datapath.sv
module burst_rx_datapath
  import burst_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic           bitClk,
  input  logic           serData,
  input  logic           sysClk,
  input  logic           rstN,
  input  rxStrobes_t     strobes,
  output logic [7:0]     outData,
  output logic           outValid,
  output logic [PW-1:0]  occ,
  output logic           dropPulse
);

  localparam int AW = PW - 1;
  localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [2:0]    bitCnt;
  logic [6:0]    shiftReg;
  logic [7:0]    byteNext;
  logic          byteDone;
  logic          fullW;
  logic          dropTgl;
  logic [PW-1:0] wbin, wbinNext, wgray;
  logic [PW-1:0] rgW1, rgW2, rbinW;
  logic [PW-1:0] rbin, rbinNext, rgray;
  logic [PW-1:0] wgS1, wgS2, wbinR;
  logic [2:0]    dropSync;

  assign byteNext = {shiftReg, serData};
  assign byteDone = (bitCnt == 3'd7);
  assign wbinNext = wbin + 1'b1;
  assign rbinNext = rbin + 1'b1;

  always_comb begin
    for (int i = 0; i <= AW; i++) begin
      rbinW[i] = ^(rgW2 >> i);
      wbinR[i] = ^(wgS2 >> i);
    end
  end

  assign fullW = ((wbin - rbinW) == DEPTH_W);

  // bit clock domain: packing and write side
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      wbin     <= '0;
      wgray    <= '0;
      rgW1     <= '0;
      rgW2     <= '0;
      dropTgl  <= 1'b0;
    end else begin
      bitCnt   <= bitCnt + 3'd1;
      shiftReg <= byteNext[6:0];
      rgW1     <= rgray;
      rgW2     <= rgW1;
      if (byteDone) begin
        if (fullW) begin
          dropTgl <= ~dropTgl;
        end else begin
          wbin  <= wbinNext;
          wgray <= wbinNext ^ (wbinNext >> 1);
        end
      end
    end
  end

  always_ff @(posedge bitClk) begin
    if (byteDone && !fullW) mem[wbin[AW-1:0]] <= byteNext;
  end

  // system clock domain: read side
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      wgS1     <= '0;
      wgS2     <= '0;
      rbin     <= '0;
      rgray    <= '0;
      dropSync <= '0;
    end else begin
      wgS1     <= wgray;
      wgS2     <= wgS1;
      dropSync <= {dropSync[1:0], dropTgl};
      if (strobes.pop) begin
        rbin  <= rbinNext;
        rgray <= rbinNext ^ (rbinNext >> 1);
      end
    end
  end

  assign outValid  = (rbin != wbinR);
  assign outData   = mem[rbin[AW-1:0]];
  assign occ       = wbinR - rbin;
  assign dropPulse = dropSync[2] ^ dropSync[1];

  // R9: an untaken byte stays presented
  p_hold_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    (outValid && !strobes.pop) |=> (outValid && $stable(outData)));

  // R7: the stored count never passes the capacity
  p_no_overflow_r7: assert property (@(posedge sysClk) disable iff (!rstN)
    occ <= DEPTH_W);

endmodule

// File: rtl/burst_rx_control.sv
module burst_rx_control
  import burst_rx_pkg::*;
#(
  parameter int PW        = 5,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 11
) (
  input  logic           sysClk,
  input  logic           rstN,
  input  logic [PW-1:0]  occ,
  input  logic           outValid,
  input  logic           outReady,
  input  logic           dropPulse,
  input  logic           clrOvf,
  output rxStrobes_t     strobes,
  output logic           dataReq,
  output logic           overflow
);

  localparam logic [PW-1:0] LOW_W  = PW'(LOW_MARK);
  localparam logic [PW-1:0] HIGH_W = PW'(HIGH_MARK);

  always_comb begin
    strobes.pop = outValid & outReady;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      dataReq  <= 1'b1;
      overflow <= 1'b0;
    end else begin
      if (occ <= LOW_W)       dataReq <= 1'b1;
      else if (occ > HIGH_W)  dataReq <= 1'b0;
      if (dropPulse)          overflow <= 1'b1;
      else if (clrOvf)        overflow <= 1'b0;
    end
  end

  p_req_fall_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(dataReq) |-> ($past(occ) > HIGH_W));

  p_req_rise_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(dataReq) |-> ($past(occ) <= LOW_W));

  p_ovf_sticky_r8: assert property (@(posedge sysClk) disable iff (!rstN)
    (overflow && !clrOvf) |=> overflow);

  p_pop_nonempty_r4: assert property (@(posedge sysClk) disable iff (!rstN)
    strobes.pop |-> (occ != '0));

endmodule

// File: rtl/burst_stream_rx.sv
module burst_stream_rx
  import burst_rx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 11
) (
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       serData,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  output logic       dataReq,
  output logic       overflow,
  input  logic       clrOvf
);

  localparam int PW = $clog2(DEPTH) + 1;

  rxStrobes_t    strobes;
  logic [PW-1:0] occ;
  logic          dropPulse;

  burst_rx_datapath #(.DEPTH(DEPTH), .PW(PW)) u_datapath (
    .bitClk    (bitClk),
    .serData   (serData),
    .sysClk    (sysClk),
    .rstN      (rstN),
    .strobes   (strobes),
    .outData   (outData),
    .outValid  (outValid),
    .occ       (occ),
    .dropPulse (dropPulse)
  );

  burst_rx_control #(.PW(PW), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_control (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .occ       (occ),
    .outValid  (outValid),
    .outReady  (outReady),
    .dropPulse (dropPulse),
    .clrOvf    (clrOvf),
    .strobes   (strobes),
    .dataReq   (dataReq),
    .overflow  (overflow)
  );

endmodule

// File: tb/test_burst_stream_rx.sv
module test_burst_stream_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LOW_MARK   = 2;
  localparam int HIGH_MARK  = 5;

  logic       sysClk = 1'b0;
  logic       rstN, bitClk, serData, outReady, clrOvf;
  logic [7:0] outData;
  logic       outValid, dataReq, overflow;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] expQ [$];
  logic reqM = 1'b1;

  burst_stream_rx #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) i_burst_stream_rx (
    .sysClk(sysClk), .rstN(rstN), .bitClk(bitClk), .serData(serData),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .dataReq(dataReq), .overflow(overflow), .clrOvf(clrOvf)
  );

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic updReq();
    if (expQ.size() <= LOW_MARK) reqM = 1'b1;
    else if (expQ.size() > HIGH_MARK) reqM = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge sysClk);
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    #5 bitClk = 1'b1;
    #7 bitClk = 1'b0;
    #1;
  endtask

  task automatic pushByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    if (expQ.size() < DEPTH) expQ.push_back(b);
    updReq();
  endtask

  task automatic popCheck(input string tag);
    logic [7:0] e;
    @(negedge sysClk);
    e = expQ.pop_front();
    check({tag, " valid"}, int'(outValid), 1);
    check({tag, " data"}, int'(outData), int'(e));
    outReady = 1'b1;
    @(negedge sysClk);
    outReady = 1'b0;
    updReq();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] held;
    rstN = 1'b0; bitClk = 1'b0; serData = 1'b0; outReady = 1'b0; clrOvf = 1'b0;
    repeat (4) @(negedge sysClk);
    check("R1 valid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge sysClk);
    check("R1 valid", int'(outValid), 0);
    check("R1 dataReq", int'(dataReq), 1);
    check("R1 overflow", int'(overflow), 0);

    // R2: MSB-first packing
    pushByte(8'hA5);
    settle();
    popCheck("R2 A5");
    pushByte(8'h01);
    settle();
    popCheck("R2 01");
    settle();
    check("R4 empty after pops", int'(outValid), 0);

    // R3: byte split across two bursts
    for (int i = 7; i >= 4; i--) sendBit(1'(8'h3C >> i));
    settle();
    check("R3 partial byte not valid", int'(outValid), 0);
    for (int i = 3; i >= 0; i--) sendBit(1'(8'h3C >> i));
    expQ.push_back(8'h3C);
    settle();
    popCheck("R3 joined byte");
    settle();

    // R4/R5/R6: fill sweep then drain sweep
    for (int n = 0; n < DEPTH; n++) begin
      pushByte(8'(n * 37 + 11));
      settle();
      check($sformatf("R5 dataReq at level %0d", n + 1), int'(dataReq), int'(reqM));
    end
    for (int n = 0; n < DEPTH; n++) begin
      popCheck("R4 order");
      settle();
      check($sformatf("R6 dataReq at level %0d", expQ.size()), int'(dataReq), int'(reqM));
    end
    check("R4 drained", int'(outValid), 0);

    // R7: overfill by two bytes
    for (int n = 0; n < DEPTH + 2; n++) pushByte(8'(n * 53 + 7));
    settle();
    check("R7 overflow set", int'(overflow), 1);
    check("R5 dataReq full", int'(dataReq), 0);

    // R9: hold while not ready
    @(negedge sysClk);
    held = outData;
    for (int k = 0; k < 5; k++) begin
      @(negedge sysClk);
      check("R9 valid held", int'(outValid), 1);
      check("R9 data held", int'(outData), int'(held));
    end

    for (int n = 0; n < DEPTH; n++) popCheck("R7 stored bytes intact");
    settle();
    check("R7 dropped bytes absent", int'(outValid), 0);

    // R8: sticky until cleared
    check("R8 overflow after drain", int'(overflow), 1);
    pushByte(8'h6E);
    settle();
    check("R8 overflow after good byte", int'(overflow), 1);
    popCheck("R8 good byte");
    @(negedge sysClk);
    clrOvf = 1'b1;
    @(negedge sysClk);
    clrOvf = 1'b0;
    settle();
    check("R8 overflow cleared", int'(overflow), 0);
    check("R6 dataReq empty", int'(dataReq), 1);

    summary();
    $finish;
  end

endmodule